// File: doc/BRIEF.md
# SAR ADC Serial Output Interface

This block is the converter-side serial port of an 18-bit successive-approximation ADC running in a 4-wire chip-select mode that reports completion on the data line. The host controls sampling with a convert-start line. It uses a second line, the select line, to choose whether the part answers, and it clocks the result out with a serial clock. A rising convert-start edge while the select line is high ends acquisition and starts a conversion. The data line floats for the whole conversion. When the conversion finishes the line is pulled actively low. This low level is the busy indication, which the host can take as an interrupt. The result bits then follow, most significant first, one per falling edge of the serial clock.

The conversion core is modelled outside the block. It supplies a one-cycle done strobe and the result word. A parameterised cycle count sets the minimum conversion time. The tri-state output is given as a data value and an output-enable. All host lines are sampled on the block clock and are assumed to be already synchronous to it.

Top module: `adc_serial_port`

## Requirements
- R1: In acquisition, a rising edge on `cnvst` while `sdi` is 1 starts a conversion, and `sdoOe` is 0 after that clock edge.
- R2: A rising edge on `cnvst` while `sdi` is 0 starts no conversion. No busy indication appears afterwards, even if `convDone` pulses, and the block stays in acquisition.
- R3: In acquisition with no readback in progress, `sdoOe`=1 and `sdo`=0 one cycle after `cnvst` and `sdi` are both sampled low. With either line high, `sdoOe`=0.
- R4: During a conversion `sdoOe` stays 0. The conversion ends on the later of the CONV_CYCLES-th cycle after the start edge and the cycle in which `convDone` is high (or was high earlier in that conversion). If `sdi` is 0 at that edge, `sdoOe`=1 and `sdo`=0 follow (busy bit).
- R5: During readback, the k-th falling edge of `sclk` (k = 1..18) launches result bit D(18-k) on `sdo`, so the MSB comes first.
- R6: The 19th falling edge of `sclk` in a readback sets `sdoOe` to 0 and returns the block to acquisition.
- R7: A rising edge on `cnvst` during readback sets `sdoOe` to 0 at once. If `sdi` is 1 at that edge, a new conversion starts.
- R8: If `sdi` is 1 when the conversion ends, `sdo` is not driven. No busy bit and no readback follow, and later `sclk` edges have no effect.
- R9: The result word is captured at the `convDone` strobe. Changes on `resultWord` after the strobe do not alter the bits read back.
- R10: Synchronous reset puts the block in acquisition with `sdoOe`=0 and the bit counter cleared. The next readback starts again from D17.
- R11: Falling `sclk` edges during a conversion shift nothing. The first falling edge after the busy bit still launches D17.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| cnvst | input | 1 | Convert-start level from the host |
| sdi | input | 1 | Select line from the host |
| sclk | input | 1 | Serial clock level from the host |
| convDone | input | 1 | One-cycle strobe from the conversion core |
| resultWord | input | DATA_W | Conversion result, valid with `convDone` |
| sdo | output | 1 | Serial data value |
| sdoOe | output | 1 | Output enable for `sdo` (0 = high impedance) |

## Verification
The bench builds the block with DATA_W=18 and CONV_CYCLES=8. With the short conversion window it can step through every cycle of a conversion, confirm the line floats until exactly the eighth edge, and also wait well past that count to cover a done strobe that arrives late. The full 18-bit width keeps the 19-edge readback, and its release on the last edge, true to the real frame. The tests include an abort in the middle of readback, an unselected conversion, and a reset during readback.

// File: rtl/adc_sp_pkg.sv
package adc_sp_pkg;

  typedef enum logic [1:0] {
    PH_ACQ  = 2'd0,
    PH_CONV = 2'd1,
    PH_READ = 2'd2
  } phase_e;

  // Strobes from control to datapath; at most one output action per cycle.
  typedef struct packed {
    logic idleLow;   // drive the line low while idle and both host lines low
    logic relOut;    // release the line (high impedance)
    logic capture;   // take the result word into the holding register
    logic busyLoad;  // load the shifter and drive the busy bit
    logic shiftOut;  // launch the next result bit
  } dp_strb_t;

endpackage

// File: rtl/adc_sp_edge.sv
module adc_sp_edge #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] din,
  output logic [N-1:0] rise,
  output logic [N-1:0] fall
);

  logic [N-1:0] prevLvl;

  always_ff @(posedge clk) begin
    if (rst) prevLvl <= '0;
    else     prevLvl <= din;
  end

  for (genvar gi = 0; gi < N; gi++) begin : g_edge
    assign rise[gi] = din[gi] & ~prevLvl[gi];
    assign fall[gi] = ~din[gi] & prevLvl[gi];
  end

endmodule

// File: rtl/adc_sp_ctrl.sv
module adc_sp_ctrl
  import adc_sp_pkg::*;
#(
  parameter  int DATA_W      = 18,
  parameter  int CONV_CYCLES = 40,
  localparam int BIT_W       = $clog2(DATA_W + 2),
  localparam int CNT_W       = $clog2(CONV_CYCLES + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cnvst,
  input  logic             sdi,
  input  logic             cnvstRise,
  input  logic             sclkFall,
  input  logic             convDone,
  output dp_strb_t         strb,
  output phase_e           phase,
  output logic [BIT_W-1:0] bitCnt
);

  logic [CNT_W-1:0] convCnt, nConv;
  logic             doneSeen, nDone;
  logic [BIT_W-1:0] nBit;
  phase_e           nPhase;
  logic             convLast, doneNow;

  assign convLast = (convCnt == CNT_W'(CONV_CYCLES - 1));
  assign doneNow  = doneSeen | convDone;

  always_comb begin
    nPhase = phase;
    nConv  = convCnt;
    nDone  = doneSeen;
    nBit   = bitCnt;
    strb   = '0;
    unique case (phase)
      PH_ACQ: begin
        nBit = '0;
        if (cnvstRise && sdi) begin
          nPhase      = PH_CONV;
          nConv       = '0;
          nDone       = 1'b0;
          strb.relOut = 1'b1;
        end else if (!cnvst && !sdi) begin
          strb.idleLow = 1'b1;
        end else begin
          strb.relOut = 1'b1;
        end
      end
      PH_CONV: begin
        strb.capture = convDone;
        if (convDone) nDone = 1'b1;
        if (convLast && doneNow) begin
          nDone = 1'b0;
          nBit  = '0;
          if (!sdi) begin
            nPhase        = PH_READ;
            strb.busyLoad = 1'b1;
          end else begin
            nPhase      = PH_ACQ;
            strb.relOut = 1'b1;
          end
        end else begin
          strb.relOut = 1'b1;
          if (!convLast) nConv = convCnt + 1'b1;
        end
      end
      PH_READ: begin
        if (cnvstRise) begin
          strb.relOut = 1'b1;
          nBit        = '0;
          if (sdi) begin
            nPhase = PH_CONV;
            nConv  = '0;
            nDone  = 1'b0;
          end else begin
            nPhase = PH_ACQ;
          end
        end else if (sclkFall) begin
          if (bitCnt == BIT_W'(DATA_W)) begin
            strb.relOut = 1'b1;
            nPhase      = PH_ACQ;
            nBit        = '0;
          end else begin
            strb.shiftOut = 1'b1;
            nBit          = bitCnt + 1'b1;
          end
        end
      end
      default: begin
        nPhase      = PH_ACQ;
        nBit        = '0;
        strb.relOut = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= PH_ACQ;
      convCnt  <= '0;
      doneSeen <= 1'b0;
      bitCnt   <= '0;
    end else begin
      phase    <= nPhase;
      convCnt  <= nConv;
      doneSeen <= nDone;
      bitCnt   <= nBit;
    end
  end

endmodule

// File: rtl/adc_sp_dpath.sv
module adc_sp_dpath
  import adc_sp_pkg::*;
#(
  parameter int DATA_W = 18
) (
  input  logic              clk,
  input  logic              rst,
  input  dp_strb_t          strb,
  input  logic [DATA_W-1:0] resultWord,
  output logic              sdo,
  output logic              sdoOe
);

  logic [DATA_W-1:0] holdReg;
  logic [DATA_W-1:0] shiftReg;
  logic [DATA_W-1:0] loadWord;

  // A strobe in the final conversion cycle bypasses the holding register.
  assign loadWord = strb.capture ? resultWord : holdReg;

  always_ff @(posedge clk) begin
    if (rst) begin
      holdReg <= '0;
    end else if (strb.capture) begin
      holdReg <= resultWord;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shiftReg <= '0;
    end else if (strb.busyLoad) begin
      shiftReg <= loadWord;
    end else if (strb.shiftOut) begin
      shiftReg <= {shiftReg[DATA_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sdo   <= 1'b0;
      sdoOe <= 1'b0;
    end else if (strb.busyLoad || strb.idleLow) begin
      sdo   <= 1'b0;
      sdoOe <= 1'b1;
    end else if (strb.shiftOut) begin
      sdo   <= shiftReg[DATA_W-1];
    end else if (strb.relOut) begin
      sdoOe <= 1'b0;
    end
  end

endmodule

// File: rtl/adc_serial_port.sv
module adc_serial_port
  import adc_sp_pkg::*;
#(
  parameter  int DATA_W      = 18,
  parameter  int CONV_CYCLES = 40,
  localparam int BIT_W       = $clog2(DATA_W + 2)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cnvst,
  input  logic              sdi,
  input  logic              sclk,
  input  logic              convDone,
  input  logic [DATA_W-1:0] resultWord,
  output logic              sdo,
  output logic              sdoOe
);

  logic [1:0]       riseVec, fallVec;
  logic             cnvstRise, sclkFall;
  dp_strb_t         strb;
  phase_e           phase;
  logic [BIT_W-1:0] bitCnt;

  adc_sp_edge #(.N(2)) edge_i (
    .clk  (clk),
    .rst  (rst),
    .din  ({sclk, cnvst}),
    .rise (riseVec),
    .fall (fallVec)
  );

  assign cnvstRise = riseVec[0];
  assign sclkFall  = fallVec[1];

  adc_sp_ctrl #(.DATA_W(DATA_W), .CONV_CYCLES(CONV_CYCLES)) ctrl_i (
    .clk       (clk),
    .rst       (rst),
    .cnvst     (cnvst),
    .sdi       (sdi),
    .cnvstRise (cnvstRise),
    .sclkFall  (sclkFall),
    .convDone  (convDone),
    .strb      (strb),
    .phase     (phase),
    .bitCnt    (bitCnt)
  );

  adc_sp_dpath #(.DATA_W(DATA_W)) dpath_i (
    .clk        (clk),
    .rst        (rst),
    .strb       (strb),
    .resultWord (resultWord),
    .sdo        (sdo),
    .sdoOe      (sdoOe)
  );

endmodule

// File: rtl/adc_sp_checker.sv
module adc_sp_checker
  import adc_sp_pkg::*;
#(
  parameter  int DATA_W = 18,
  localparam int BIT_W  = $clog2(DATA_W + 2)
) (
  input logic             clk,
  input logic             rst,
  input logic             cnvst,
  input logic             sdi,
  input logic             sdo,
  input logic             sdoOe,
  input phase_e           phase,
  input logic [BIT_W-1:0] bitCnt
);

  AST_START_HIZ: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_ACQ && $rose(cnvst) && sdi) |=> (phase == PH_CONV && !sdoOe)); // R1

  AST_NO_START_UNSEL: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_ACQ && !sdi) |=> (phase != PH_CONV)); // R2

  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_ACQ && !cnvst && !sdi) |=> (sdoOe && !sdo)); // R3

  AST_CONV_HIZ: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_CONV) |-> !sdoOe); // R4

  AST_BUSY_LOW: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_READ && $past(phase) == PH_CONV) |-> (sdoOe && !sdo)); // R4

  AST_BITCNT_MAX: assert property (@(posedge clk) disable iff (rst)
    bitCnt <= BIT_W'(DATA_W)); // R6

  AST_ABORT_HIZ: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_READ && $rose(cnvst)) |=> !sdoOe); // R7

  AST_UNSEL_END_HIZ: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_ACQ && $past(phase) == PH_CONV) |-> !sdoOe); // R8

  AST_BITCNT_IDLE: assert property (@(posedge clk) disable iff (rst)
    (phase != PH_READ) |-> (bitCnt == '0)); // R10

endmodule

bind adc_serial_port adc_sp_checker #(.DATA_W(DATA_W)) chk_i (
  .clk    (clk),
  .rst    (rst),
  .cnvst  (cnvst),
  .sdi    (sdi),
  .sdo    (sdo),
  .sdoOe  (sdoOe),
  .phase  (phase),
  .bitCnt (bitCnt)
);

// File: tb/adc_serial_port_tb_top.sv
module adc_serial_port_tb_top;

  localparam int DATA_W = 18;
  localparam int CONV_C = 8;

  logic clk = 1'b0;
  logic rst, cnvst, sdi, sclk, convDone;
  logic [DATA_W-1:0] resultWord;
  logic sdo, sdoOe;

  always #2 clk = ~clk;

  adc_serial_port #(.DATA_W(DATA_W), .CONV_CYCLES(CONV_C)) dut_i (
    .clk(clk), .rst(rst), .cnvst(cnvst), .sdi(sdi), .sclk(sclk),
    .convDone(convDone), .resultWord(resultWord), .sdo(sdo), .sdoOe(sdoOe)
  );

  typedef struct {
    logic  oe;
    logic  d;
    string tag;
  } exp_t;

  exp_t expQ[$];
  event sampleEv;
  int   vectors = 0;
  int   miscompares = 0;
  bit   finished = 0;

  localparam logic [DATA_W-1:0] W1   = 18'h2A5C3;
  localparam logic [DATA_W-1:0] W2   = 18'h3C0A5;
  localparam logic [DATA_W-1:0] JUNK = 18'h15555;

  // Monitor: compares each queued expectation against the live outputs.
  initial begin
    forever begin
      @(sampleEv);
      while (expQ.size() > 0) begin
        exp_t e;
        e = expQ.pop_front();
        vectors++;
        if (sdoOe !== e.oe || (e.oe && sdo !== e.d)) begin
          miscompares++;
          $display("FAIL %s: got oe=%0b sdo=%0b, expected oe=%0b sdo=%0b",
                   e.tag, sdoOe, sdo, e.oe, e.d);
        end
      end
    end
  end

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic expectOut(logic oe, logic d, string tag);
    exp_t e;
    e.oe = oe; e.d = d; e.tag = tag;
    expQ.push_back(e);
    -> sampleEv;
    #0;
  endtask

  // Assumes the start edge has just been applied; done pulses on cycle 1.
  task automatic runConversion(logic [DATA_W-1:0] w);
    for (int k = 1; k <= CONV_C; k++) begin
      convDone   = (k == 1);
      resultWord = (k == 1) ? w : JUNK;
      tick();
      if (k < CONV_C) expectOut(1'b0, 1'b0, "R4");
      else            expectOut(1'b1, 1'b0, "R4");
    end
    convDone = 1'b0;
  endtask

  task automatic readBits(logic [DATA_W-1:0] w, int n, string tag);
    for (int k = 0; k < n; k++) begin
      sclk = 1'b1; tick();
      sclk = 1'b0; tick();
      expectOut(1'b1, w[DATA_W-1-k], tag);
    end
  endtask

  task automatic startConv();
    cnvst = 1'b0; sdi = 1'b1; tick();
    cnvst = 1'b1; tick();
    expectOut(1'b0, 1'b0, "R1");
    sdi = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL all: watchdog expired, got running, expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; cnvst = 1'b0; sdi = 1'b0; sclk = 1'b0;
    convDone = 1'b0; resultWord = '0;
    @(negedge clk);
    tick(); tick();
    expectOut(1'b0, 1'b0, "R10");
    rst = 1'b0; tick();
    expectOut(1'b1, 1'b0, "R3");
    sdi = 1'b1; tick();
    expectOut(1'b0, 1'b0, "R3");

    // Basic conversion, result word changes after the strobe (R9).
    cnvst = 1'b1; tick();
    expectOut(1'b0, 1'b0, "R1");
    sdi = 1'b0;
    runConversion(W1);
    readBits(W1, DATA_W, "R9");
    sclk = 1'b1; tick();
    sclk = 1'b0; tick();
    expectOut(1'b0, 1'b0, "R6");
    tick();
    expectOut(1'b0, 1'b0, "R6");

    // Late done strobe, serial clock toggling during conversion (R11).
    startConv();
    for (int k = 0; k < CONV_C + 3; k++) begin
      sclk = ~sclk; tick();
      expectOut(1'b0, 1'b0, "R11");
    end
    sclk = 1'b0;
    convDone = 1'b1; resultWord = W2; tick();
    expectOut(1'b1, 1'b0, "R4");
    convDone = 1'b0; resultWord = JUNK;
    readBits(W2, 5, "R11");
    cnvst = 1'b0; tick();
    expectOut(1'b1, W2[DATA_W-5], "R7");
    sdi = 1'b1; cnvst = 1'b1; tick();
    expectOut(1'b0, 1'b0, "R7");

    // That new conversion ends with the select line high (R8).
    for (int k = 1; k <= CONV_C + 2; k++) begin
      convDone = (k == 1); resultWord = W1;
      tick();
      expectOut(1'b0, 1'b0, "R8");
    end
    convDone = 1'b0;
    sclk = 1'b1; tick();
    sclk = 1'b0; tick();
    expectOut(1'b0, 1'b0, "R8");

    // Rising convert-start with select low: no conversion (R2).
    cnvst = 1'b0; sdi = 1'b0; tick();
    expectOut(1'b1, 1'b0, "R3");
    cnvst = 1'b1; tick();
    expectOut(1'b0, 1'b0, "R2");
    for (int k = 1; k <= CONV_C + 2; k++) begin
      convDone = (k == 2); resultWord = W2;
      tick();
      expectOut(1'b0, 1'b0, "R2");
    end
    convDone = 1'b0;
    cnvst = 1'b0; tick();
    expectOut(1'b1, 1'b0, "R2");

    // Reset during readback, then a full frame from D17 (R10).
    startConv();
    runConversion(W1);
    readBits(W1, 3, "R5");
    rst = 1'b1; cnvst = 1'b0; sdi = 1'b1; tick();
    expectOut(1'b0, 1'b0, "R10");
    rst = 1'b0; tick();
    expectOut(1'b0, 1'b0, "R10");
    startConv();
    runConversion(W2);
    readBits(W2, DATA_W, "R10");
    sclk = 1'b1; tick();
    sclk = 1'b0; tick();
    expectOut(1'b0, 1'b0, "R6");

    tick();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule